// File: doc/BRIEF.md
# Programmable Asynchronous Character Transmitter

This block turns one parallel character, written by a host into a single holding register, into an asynchronous serial frame on one output line. Each frame is a low start bit, five to eight data bits sent least significant first, an optional parity bit, and a high stop interval of one, one and a half or two bit times. Frame shape and the bit-rate divisor are inputs. They are captured when each character begins, so they may be changed between characters without corrupting the one in flight.

Bit timing comes from an external transmit clock. Its falling edges are detected in the system clock domain, and one bit time is 1, 16 or 64 of those edges. A character leaves the holding register only when the clear-to-send input and the transmit-enable input are both high. A character already in flight always completes. A break input holds the line low for as long as it is set, without disturbing the sequencer underneath. Two flags tell the host whether a write is welcome and whether everything has drained.

The sequencer has five states. IDLE drives mark. START drives space. DATA drives the current data bit. PARITY drives the parity bit. STOP drives mark. The transitions are:
- launch: IDLE→START on a clock edge when a character is pending and both gates are open.
- first-bit: START→DATA when the bit time ends.
- to-parity: DATA→PARITY after the last data bit when parity is on.
- to-stop: DATA→STOP after the last data bit when parity is off.
- parity-done: PARITY→STOP.
- chain: STOP→START when the stop interval ends and another character may launch.
- drain: STOP→IDLE when the stop interval ends and no character may launch.

Top module: `async_tx_framer`

## Requirements
- R1: Every frame begins with a start bit driven low for exactly one bit time.
- R2: Data bits follow the start bit least significant bit first. `data_len_i` selects the count: 0→5, 1→6, 2→7, 3→8. Upper bits of the written byte are not sent.
- R3: When `par_en_i` is 1, one parity bit follows the last data bit, computed over the sent data bits only. With `par_odd_i`=1 the data plus parity hold an odd number of ones; with `par_odd_i`=0 they hold an even number.
- R4: The stop interval is driven high. `stop_sel_i`=0 gives 1 bit time, 1 gives 1.5 bit times (at divisor 1 it gives 2 bit times), and 2 or 3 give 2 bit times.
- R5: One bit time spans a number of transmit-clock falling edges set by `baud_sel_i`: 0→1, 1→16, 2 or 3→64. All line changes follow a detected falling edge.
- R6: With no frame in progress and break clear, `txd_o` is high.
- R7: While `brk_i` is 1, `txd_o` is low. The sequencer keeps running, so a frame in progress continues where it would have been.
- R8: A pending character starts only while `cts_i` and `tx_en_i` are both 1. Dropping either during a frame does not cut that frame short.
- R9: `tx_rdy_o` is 1 exactly when the holding register is empty and `cts_i` and `tx_en_i` are both 1.
- R10: `tx_empty_o` is 1 exactly when the holding register is empty and no frame is in progress.
- R11: A write while the holding register is full is discarded, and the held character is kept.
- R12: If a character is pending and the gates are open when a stop interval ends, the next start bit begins immediately, with no extra idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txc_i | input | 1 | Transmit bit clock, falling edges counted |
| baud_sel_i | input | 2 | Divisor select: 0→1, 1→16, 2/3→64 |
| data_len_i | input | 2 | Data bit count select: 0→5 … 3→8 |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1 odd parity, 0 even parity |
| stop_sel_i | input | 2 | Stop select: 0→1, 1→1.5, 2/3→2 |
| cts_i | input | 1 | Clear-to-send, active high |
| tx_en_i | input | 1 | Transmit enable, active high |
| brk_i | input | 1 | Force line low while set |
| wr_i | input | 1 | Holding register write strobe |
| wdata_i | input | 8 | Character to send |
| txd_o | output | 1 | Serial output line |
| tx_rdy_o | output | 1 | Holding register can accept a write |
| tx_empty_o | output | 1 | Holding register and shifter both idle |

## Verification
The assertions assume that each level of `txc_i` lasts longer than the synchronizer depth in system clocks, so each falling edge yields one isolated tick. They also assume that `wr_i` is a one-cycle strobe. The bench drives the transmit clock at a quarter of the system clock rate. It changes the framing inputs only while the line is idle or after a character has launched, and it pulses each write for exactly one cycle. Frame contents are decoded at mid-bit positions derived from the divisor. Stop lengths and back-to-back chaining are measured as exact start-to-start distances in system clocks.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int CHAR_W   = 8;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] dlen;
        logic       pen;
        logic [1:0] stop;
        logic [1:0] baud;
    } frame_cfg_t;
endpackage

// File: rtl/atx_clk_edge.sv
module atx_clk_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txc_i,
    output logic fall_o
);
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], txc_i};
    end

    assign fall_o = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];

    // one tick per falling edge of the bit clock
    p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/atx_holding.sv
module atx_holding #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          take_i,
    output logic          full_o,
    output logic [DW-1:0] data_o
);
    logic          full_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take_i) begin
            full_q <= 1'b0;
        end else if (wr_i && !full_q) begin
            full_q <= 1'b1;
            data_q <= wdata_i;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

    p_take_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> full_q);
    p_hold_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take_i) |=> (full_q && $stable(data_q)));
endmodule

// File: rtl/atx_bit_timer.sv
module atx_bit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    assign done_o = tick_i && (cnt_q == len_i - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (tick_i)  cnt_q <= done_o ? '0 : cnt_q + CNT_W'(1);
    end

    p_cnt_in_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (cnt_q < len_i));
endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer
    import atx_pkg::*;
#(
    parameter int DIV_MID     = 16,
    parameter int DIV_HI      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txc_i,
    input  logic [1:0]        baud_sel_i,
    input  logic [1:0]        data_len_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic [1:0]        stop_sel_i,
    input  logic              cts_i,
    input  logic              tx_en_i,
    input  logic              brk_i,
    input  logic              wr_i,
    input  logic [CHAR_W-1:0] wdata_i,
    output logic              txd_o,
    output logic              tx_rdy_o,
    output logic              tx_empty_o
);
    localparam int CNT_W = $clog2(2 * DIV_HI + 1);
    localparam int IDX_W = $clog2(CHAR_W);

    tx_state_e         state_q, state_d;
    frame_cfg_t        cfg_q;
    logic [CHAR_W-1:0] shift_q, hold_data;
    logic [IDX_W-1:0]  idx_q, last_idx;
    logic              par_q, hold_full, tick, bit_done, can_start, load, line;
    logic [CNT_W-1:0]  factor, bit_len;

    function automatic logic [CNT_W-1:0] factor_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(DIV_MID);
            default: return CNT_W'(DIV_HI);
        endcase
    endfunction

    function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                       input logic [1:0] len, input logic odd);
        logic p;
        p = odd;
        for (int i = 0; i < CHAR_W; i++)
            if (i < MIN_BITS + int'(len)) p = p ^ d[i];
        return p;
    endfunction

    atx_clk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .txc_i(txc_i), .fall_o(tick)
    );

    atx_holding #(.DW(CHAR_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wdata_i(wdata_i),
        .take_i(load), .full_o(hold_full), .data_o(hold_data)
    );

    atx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .clear_i(state_q == ST_IDLE),
        .len_i(bit_len), .done_o(bit_done)
    );

    assign can_start = hold_full && cts_i && tx_en_i;
    assign load      = can_start && ((state_q == ST_IDLE && tick) ||
                                     (state_q == ST_STOP && bit_done));
    assign last_idx  = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_q.dlen);
    assign factor    = factor_of(cfg_q.baud);

    always_comb begin
        bit_len = factor;
        if (state_q == ST_STOP) begin
            case (cfg_q.stop)
                2'd0:    bit_len = factor;
                2'd1:    bit_len = (cfg_q.baud == 2'd0) ? factor << 1
                                                        : factor + (factor >> 1);
                default: bit_len = factor << 1;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && can_start) state_d = ST_START;
            ST_START:  if (bit_done) state_d = ST_DATA;
            ST_DATA:   if (bit_done && idx_q == last_idx)
                           state_d = cfg_q.pen ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done) state_d = ST_STOP;
            ST_STOP:   if (bit_done) state_d = can_start ? ST_START : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // character datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            par_q   <= 1'b0;
            idx_q   <= '0;
            cfg_q   <= '0;
        end else if (load) begin
            shift_q    <= hold_data;
            par_q      <= parity_of(hold_data, data_len_i, par_odd_i);
            idx_q      <= '0;
            cfg_q.dlen <= data_len_i;
            cfg_q.pen  <= par_en_i;
            cfg_q.stop <= stop_sel_i;
            cfg_q.baud <= baud_sel_i;
        end else if (state_q == ST_DATA && bit_done) begin
            shift_q <= shift_q >> 1;
            idx_q   <= idx_q + IDX_W'(1);
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_START:  line = 1'b0;
            ST_DATA:   line = shift_q[0];
            ST_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

    assign txd_o      = line & ~brk_i;
    assign tx_rdy_o   = !hold_full && cts_i && tx_en_i;
    assign tx_empty_o = !hold_full && (state_q == ST_IDLE);

    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && !brk_i) |-> !txd_o);
    p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !brk_i) |-> txd_o);
    p_idle_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !brk_i) |-> txd_o);
    p_launch_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) != ST_START) |-> $past(cts_i && tx_en_i));
    p_move_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(tick));
endmodule

// File: tb/async_tx_framer_test.sv
`timescale 1ns/1ps
module async_tx_framer_test;
    logic       clk = 1'b0, rst_n = 1'b0, txc;
    logic [1:0] baud_sel = 2'd1, data_len = 2'd3, stop_sel = 2'd0;
    logic       par_en = 1'b0, par_odd = 1'b0, cts = 1'b1, tx_en = 1'b1, brk = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       txd, tx_rdy, tx_empty;
    int         checks = 0, errors = 0;
    longint     cyc = 0;

    async_tx_framer uut (
        .clk(clk), .rst_n(rst_n), .txc_i(txc), .baud_sel_i(baud_sel),
        .data_len_i(data_len), .par_en_i(par_en), .par_odd_i(par_odd),
        .stop_sel_i(stop_sel), .cts_i(cts), .tx_en_i(tx_en), .brk_i(brk),
        .wr_i(wr), .wdata_i(wdata), .txd_o(txd), .tx_rdy_o(tx_rdy),
        .tx_empty_o(tx_empty)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    initial begin
        txc = 1'b1;
        #1;
        forever #10 txc = ~txc;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1;
        wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // decode one frame at mid-bit points; t0 = cycle of the start edge
    task automatic get_frame(input logic [7:0] d, input int nb, input bit pe,
                             input bit po, input int f, output longint t0);
        int  w = 0;
        int  bc = f * 4;
        logic exp_p;
        while (txd !== 1'b0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        t0 = cyc;
        if (w >= 20000) begin
            chk("R1", "no start bit seen", 0, 1);
            return;
        end
        idle(bc / 2);
        chk("R1", "start bit", int'(txd), 0);
        exp_p = po;
        for (int i = 0; i < nb; i++) begin
            idle(bc);
            chk("R2", $sformatf("data bit %0d", i), int'(txd), int'(d[i]));
            exp_p = exp_p ^ d[i];
        end
        if (pe) begin
            idle(bc);
            chk("R3", "parity bit", int'(txd), int'(exp_p));
        end
        idle(bc);
        chk("R4", "stop level", int'(txd), 1);
    endtask

    task automatic set_cfg(input logic [1:0] b, input logic [1:0] dl, input bit pe,
                           input bit po, input logic [1:0] st);
        baud_sel = b; data_len = dl; par_en = pe; par_odd = po; stop_sel = st;
    endtask

    // two chained characters; start-to-start distance is checked
    task automatic pair(input logic [7:0] a, input logic [7:0] b, input int nb,
                        input bit pe, input bit po, input int f, input int exp_cyc,
                        input string req);
        longint ta, tb;
        fork
            get_frame(a, nb, pe, po, f, ta);
            begin
                put(a);
                chk("R9", "rdy low while held", int'(tx_rdy), 0);
                chk("R10", "empty low while held", int'(tx_empty), 0);
                while (tx_rdy !== 1'b1) @(negedge clk);
                put(b);
            end
        join
        get_frame(b, nb, pe, po, f, tb);
        chk(req, "start-to-start cycles (R12 chaining)", int'(tb - ta), exp_cyc);
    endtask

    task automatic t_reset;
        chk("R6", "txd after reset", int'(txd), 1);
        chk("R9", "rdy after reset", int'(tx_rdy), 1);
        chk("R10", "empty after reset", int'(tx_empty), 1);
    endtask

    task automatic t_x16_8n1;
        set_cfg(2'd1, 2'd3, 1'b0, 1'b0, 2'd0);
        pair(8'hA5, 8'h3C, 8, 1'b0, 1'b0, 16, (9 * 16 + 16) * 4, "R5");
        idle(200);
        chk("R10", "empty after drain", int'(tx_empty), 1);
        chk("R6", "idle mark after drain", int'(txd), 1);
    endtask

    task automatic t_even_7_onehalf;
        set_cfg(2'd1, 2'd2, 1'b1, 1'b0, 2'd1);
        pair(8'hD3, 8'h80, 7, 1'b1, 1'b0, 16, (9 * 16 + 24) * 4, "R4");
        idle(200);
    endtask

    task automatic t_odd_5_x1;
        set_cfg(2'd0, 2'd0, 1'b1, 1'b1, 2'd1);
        pair(8'hF5, 8'h0A, 5, 1'b1, 1'b1, 1, (7 + 2) * 4, "R4");
        idle(40);
    endtask

    task automatic t_x64_6_two;
        set_cfg(2'd2, 2'd1, 1'b0, 1'b0, 2'd2);
        pair(8'h2D, 8'h12, 6, 1'b0, 1'b0, 64, (7 * 64 + 128) * 4, "R5");
        idle(700);
    endtask

    task automatic t_cts_gate;
        longint t;
        int lows = 0;
        set_cfg(2'd1, 2'd3, 1'b0, 1'b0, 2'd0);
        cts = 1'b0;
        put(8'h66);
        put(8'h99);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R8", "no launch while cts low", lows, 0);
        chk("R9", "rdy low with cts low", int'(tx_rdy), 0);
        chk("R10", "empty low with char held", int'(tx_empty), 0);
        cts = 1'b1;
        get_frame(8'h66, 8, 1'b0, 1'b0, 16, t);
        lows = 0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R11", "second write discarded", lows, 0);
        chk("R10", "empty after single frame", int'(tx_empty), 1);
    endtask

    task automatic t_en_drop;
        longint t;
        set_cfg(2'd1, 2'd3, 1'b0, 1'b0, 2'd0);
        fork
            get_frame(8'hC3, 8, 1'b0, 1'b0, 16, t);
            begin
                put(8'hC3);
                idle(200);
                tx_en = 1'b0;
            end
        join
        chk("R9", "rdy low with enable off", int'(tx_rdy), 0);
        idle(100);
        tx_en = 1'b1;
        idle(4);
        chk("R9", "rdy back with enable on", int'(tx_rdy), 1);
    endtask

    task automatic t_break;
        int highs = 0;
        brk = 1'b1;
        idle(2);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (txd !== 1'b0) highs++;
        end
        chk("R7", "break holds line low", highs, 0);
        chk("R10", "break leaves empty set", int'(tx_empty), 1);
        brk = 1'b0;
        idle(2);
        chk("R6", "mark after break release", int'(txd), 1);
        set_cfg(2'd1, 2'd3, 1'b0, 1'b0, 2'd0);
        put(8'hFF);
        while (txd !== 1'b0) @(negedge clk);
        idle(2 * 64);
        brk = 1'b1;
        idle(5);
        chk("R7", "break inside frame", int'(txd), 0);
        brk = 1'b0;
        idle(5);
        chk("R7", "frame resumes after break", int'(txd), 1);
        chk("R10", "frame still in progress", int'(tx_empty), 0);
        idle(10 * 64);
        chk("R10", "frame ended after break", int'(tx_empty), 1);
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        t_reset();
        t_x16_8n1();
        t_even_7_onehalf();
        t_odd_5_x1();
        t_x64_6_two();
        t_cts_gate();
        t_en_drop();
        t_break();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule